// File: doc/BRIEF.md
# Two-Count PWM Generator

A single pulse-width-modulated output whose waveform is set by two separate counts. One count gives the number of prescaled ticks the output spends in its active level. The other gives the number it spends inactive. The period is the sum of the two, and the duty is the active count divided by that sum. The block has a small word-addressed register port that holds both counts and a configuration word. The configuration word holds a run bit, a tick-source choice, an output-polarity flip and a prescaler field.

Counting is synchronous to one clock, `clk`. A second, slower time base arrives as the single-cycle strobe `alt_tick` in the same domain. A prescaler divides the chosen source by (N+1). Each divided tick advances a phase counter, which moves from the active phase to the inactive phase and then back. Counts written while the generator runs go to live registers. They are copied into working copies only when a period begins, so the waveform never shows a truncated or stretched cycle.

Top module: `onoff_pwm`

## Requirements
- R1: After reset all registers read zero and `pwm_o` is 0.
- R2: Address word 0 (byte offset 0x0) holds the active count, word 1 (0x4) holds the inactive count and word 2 (0x8) holds the configuration. Each reads back the last value written. Configuration bits 31:7 read zero whatever was written, and word 3 (0xC) always reads zero.
- R3: The configuration fields are: bit 0 run, bit 1 tick source, bit 2 polarity, bits 6:3 prescaler. With source 0 and prescaler 0, the output is active for exactly `hi` cycles and then inactive for `lo` cycles, repeating. The first active cycle is the second cycle after the edge that writes run=1.
- R4: With prescaler value N, every phase lasts its count times (N+1) cycles.
- R5: With tick-source bit set, the phase counter advances only in cycles where `alt_tick` is 1. With no strobes, the output holds its current level.
- R6: With polarity bit set, `pwm_o` is the complement of the un-inverted waveform.
- R7: An active count of 0 holds the output at the inactive level. An inactive count of 0 with a non-zero active count holds it at the active level.
- R8: Count writes take effect only at the start of the next period. A write whose clock edge coincides with a period start applies to the period that begins there.
- R9: From the cycle after run is cleared, `pwm_o` equals the polarity bit, meaning inactive. Setting run again starts a fresh period with the active phase one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and counting |
| rst_n | input | 1 | Asynchronous reset, active low |
| alt_tick | input | 1 | Slow time-base strobe, used when the tick-source bit is set |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Byte address; bits 3:2 choose the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_o | output | 1 | PWM output with polarity applied |

## Verification
A count write and a period boundary can land on the same clock edge. A write can also arrive partway through a period. The bench provokes both with the same scheduled waveform. It writes a new active count in the middle of a period, and later writes another on the exact edge where the inactive phase ends. It judges the result cycle by cycle against a hand-derived sequence: the old count must hold until the boundary, and the boundary write must take effect in the period it opens.

// File: rtl/onoff_pwm.sv
module onoff_pwm #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_tick,
  input  logic              wr_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_o
);
  localparam int CFG_W = 3 + PRE_W;

  logic [CNT_W-1:0] hi_r, lo_r, hi_s, lo_s, cnt;
  logic [PRE_W-1:0] pre_q, pc;
  logic en_q, src_q, inv_q, run_q, ph_hi;

  wire wr_hi  = wr_en && (addr[3:2] == 2'd0);
  wire wr_lo  = wr_en && (addr[3:2] == 2'd1);
  wire cfg_wr = wr_en && (addr[3:2] == 2'd2);

  wire [CNT_W-1:0] hi_n = wr_hi ? wdata[CNT_W-1:0] : hi_r;
  wire [CNT_W-1:0] lo_n = wr_lo ? wdata[CNT_W-1:0] : lo_r;

  wire src_tick  = src_q ? alt_tick : 1'b1;
  wire tick      = run_q && src_tick && (pc >= pre_q);
  wire hi_end    = ph_hi && (cnt == hi_s - 1'b1);
  wire lo_end    = !ph_hi && ((lo_s == '0) || (cnt == lo_s - 1'b1));
  wire per_start = (en_q && !run_q) ||
                   (tick && ((hi_end && (lo_s == '0)) || lo_end));

  wire [CFG_W-1:0] cfg_rd = {pre_q, inv_q, src_q, en_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_r  <= '0;
      lo_r  <= '0;
      en_q  <= 1'b0;
      src_q <= 1'b0;
      inv_q <= 1'b0;
      pre_q <= '0;
    end else begin
      if (wr_hi) hi_r <= wdata[CNT_W-1:0];
      if (wr_lo) lo_r <= wdata[CNT_W-1:0];
      if (cfg_wr) begin
        en_q  <= wdata[0];
        src_q <= wdata[1];
        inv_q <= wdata[2];
        pre_q <= wdata[3 +: PRE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ph_hi <= 1'b0;
      cnt   <= '0;
      pc    <= '0;
      hi_s  <= '0;
      lo_s  <= '0;
    end else if (!en_q) begin
      run_q <= 1'b0;
      ph_hi <= 1'b0;
      cnt   <= '0;
      pc    <= '0;
    end else begin
      run_q <= 1'b1;
      if (tick)
        pc <= '0;
      else if (run_q && src_tick)
        pc <= pc + 1'b1;
      if (per_start) begin
        hi_s  <= hi_n;
        lo_s  <= lo_n;
        cnt   <= '0;
        ph_hi <= (hi_n != '0);
      end else if (tick) begin
        if (hi_end) begin
          ph_hi <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (addr[3:2])
      2'd0:    rdata = DATA_W'(hi_r);
      2'd1:    rdata = DATA_W'(lo_r);
      2'd2:    rdata = DATA_W'(cfg_rd);
      default: rdata = '0;
    endcase
  end

  assign pwm_o = (en_q & run_q & ph_hi) ^ inv_q;
endmodule

module onoff_pwm_chk #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_o,
  input logic             en_q,
  input logic             inv_q,
  input logic             src_q,
  input logic [PRE_W-1:0] pre_q,
  input logic             alt_tick,
  input logic             tick,
  input logic             run_q,
  input logic             per_start,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] hi_s,
  input logic [CNT_W-1:0] lo_s
);
  // R1
  always @(posedge clk)
    if (!rst_n) reset_low_chk: assert (pwm_o == 1'b0);

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> (pwm_o == inv_q));

  // R7
  zero_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_q && hi_s == '0) |-> (pwm_o == inv_q));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !per_start) |=> ($stable(hi_s) && $stable(lo_s)));

  // R5
  alt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q && !alt_tick) |-> !tick);

  // R4
  prescale_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pre_q != '0 && !cfg_wr) |=> !tick);
endmodule

bind onoff_pwm onoff_pwm_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .pwm_o(pwm_o), .en_q(en_q), .inv_q(inv_q),
  .src_q(src_q), .pre_q(pre_q), .alt_tick(alt_tick), .tick(tick),
  .run_q(run_q), .per_start(per_start), .cfg_wr(cfg_wr),
  .hi_s(hi_s), .lo_s(lo_s)
);

// File: tb/test_onoff_pwm.sv
`timescale 1ns/1ps
module test_onoff_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alt_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm_o;
  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  onoff_pwm i_onoff_pwm (
    .clk(clk), .rst_n(rst_n), .alt_tick(alt_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 pin", {31'b0, pwm_o}, 32'd0);
    rd_chk("R1 hi", 4'h0, 0);
    rd_chk("R1 lo", 4'h4, 0);
    rd_chk("R1 cfg", 4'h8, 0);
    rst_n = 1'b1;

    // R2
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h4, 32'h1234_5678);
    wr(4'h8, 32'hFFFF_FF80);
    wr(4'hC, 32'hFFFF_FFFF);
    rd_chk("R2 hi", 4'h0, 32'hFFFF_FFFF);
    rd_chk("R2 lo", 4'h4, 32'h1234_5678);
    rd_chk("R2 cfg undefined bits", 4'h8, 32'h0);
    rd_chk("R2 word3", 4'hC, 32'h0);
    wr(4'h8, 32'h0000_0055);
    rd_chk("R2 cfg fields", 4'h8, 32'h55);
    wr(4'h8, 32'h0);

    // R3 R4 R6 R7 sweep
    for (int inv = 0; inv < 2; inv++)
      for (int pre = 0; pre < 3; pre++)
        for (int hi = 0; hi < 5; hi++)
          for (int lo = 0; lo < 5; lo++) begin
            int hc, lc, win;
            string tag;
            hc = hi * (pre + 1);
            lc = lo * (pre + 1);
            win = 2 * (hc + lc) + 4;
            tag = (hi == 0 || lo == 0) ? "R7" : (pre != 0) ? "R4" : (inv != 0) ? "R6" : "R3";
            wr(4'h8, 32'h0);
            wr(4'h0, hi);
            wr(4'h4, lo);
            wr(4'h8, (pre << 3) | (inv << 2) | 1);
            @(negedge clk);
            for (int k = 0; k < win; k++) begin
              logic act;
              act = (hc + lc == 0) ? 1'b0 : ((k % (hc + lc)) < hc);
              chk(tag, {31'b0, pwm_o}, {31'b0, act ^ inv[0]});
              @(negedge clk);
            end
          end

    // R8: mid-period write, then a write on the boundary edge
    wr(4'h8, 32'h0);
    wr(4'h0, 3);
    wr(4'h4, 3);
    wr(4'h8, 32'h1);
    @(negedge clk);
    begin
      logic [15:0] exp8;
      exp8 = 16'b1000_1100_0100_0111;
      for (int k = 0; k < 16; k++) begin
        chk("R8", {31'b0, pwm_o}, {31'b0, exp8[k]});
        if (k == 1) begin wr_en = 1'b1; addr = 4'h0; wdata = 1; end
        else if (k == 9) begin wr_en = 1'b1; addr = 4'h0; wdata = 2; end
        else wr_en = 1'b0;
        @(negedge clk);
      end
      wr_en = 1'b0;
    end

    // R5
    wr(4'h8, 32'h0);
    wr(4'h0, 2);
    wr(4'h4, 2);
    wr(4'h8, 32'h3);
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      chk("R5 stalled", {31'b0, pwm_o}, 32'd1);
      @(negedge clk);
    end
    alt_tick = 1'b1; @(negedge clk); alt_tick = 1'b0;
    chk("R5 one strobe", {31'b0, pwm_o}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R5 still held", {31'b0, pwm_o}, 32'd1);
    alt_tick = 1'b1; @(negedge clk); alt_tick = 1'b0;
    chk("R5 second strobe", {31'b0, pwm_o}, 32'd0);

    // R9
    wr(4'h8, 32'h0);
    wr(4'h0, 3);
    wr(4'h4, 3);
    wr(4'h8, 32'h5);
    @(negedge clk);
    chk("R9 running", {31'b0, pwm_o}, 32'd0);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h8; wdata = 32'h4;
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R9 disabled", {31'b0, pwm_o}, 32'd1);
      @(negedge clk);
    end
    wr(4'h8, 32'h5);
    chk("R9 restart edge", {31'b0, pwm_o}, 32'd1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      chk("R9 fresh active", {31'b0, pwm_o}, 32'd0);
      @(negedge clk);
    end
    chk("R9 then inactive", {31'b0, pwm_o}, 32'd1);

    finish_up();
  end
endmodule